// File: doc/BRIEF.md
# Two-Road Traffic Phase Controller

This block runs the lights at a crossing of two roads, A and B. It is a Moore state machine with four phases. Each road has a sensor input that is high while vehicles are waiting or passing. A road keeps its green for as long as its own sensor reports traffic. When the sensor clears, that road shows yellow for exactly one step, and then the other road receives green. The two 2-bit lamp outputs depend only on the current phase.

The phase changes only on a slow step pulse. A free-running prescaler divides the system clock to make that pulse, which lasts one cycle and repeats every `STEP_CYCLES` clocks. The default divider is sized for a 5-second step at 100 MHz. A synchronous reset returns the machine to the A-green phase and clears the prescaler.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is phase 0 and the prescaler count is cleared. Phase 0 shows A green and B red. Lamp codes are green = 2'b00, yellow = 2'b01 and red = 2'b10.
- R2: The phase changes only on the clock edge that ends a step-pulse cycle. The first such edge is the `STEP_CYCLES`-th clock edge after reset is released, and later ones follow every `STEP_CYCLES` edges. The lamps hold steady between these edges.
- R3: In phase 0 (A green, B red), a step edge with `sense_a` high keeps phase 0. `sense_b` has no effect in this phase.
- R4: In phase 0, a step edge with `sense_a` low moves to phase 1, which shows A yellow and B red.
- R5: Phase 1 always moves to phase 2 (A red, B green) on the next step edge, whatever the sensors show.
- R6: In phase 2, a step edge with `sense_b` high keeps phase 2. `sense_a` has no effect in this phase.
- R7: In phase 2, a step edge with `sense_b` low moves to phase 3, which shows A red and B yellow.
- R8: Phase 3 always moves to phase 0 on the next step edge.
- R9: The sensors are read only in the step-pulse cycle. A sensor change that is undone before that cycle has no effect.
- R10: At every moment, at least one of the two roads shows red.
- R11: A reset applied in the middle of a run restarts the prescaler. The next phase change then comes `STEP_CYCLES` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | High while road A has traffic |
| sense_b | input | 1 | High while road B has traffic |
| lamp_a | output | 2 | Light code for road A |
| lamp_b | output | 2 | Light code for road B |

## Verification
The bench builds the block with `STEP_CYCLES` set to 4, so each step lasts only a few clocks. At that size one run can visit every phase, every sensor-gated hold and exit, and a reset in mid-run. It can also check the cycle just before each step edge, which shows that nothing moves early. Four cycles also leave room to change a sensor and restore it between two step pulses.

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl #(
  parameter int STEP_CYCLES = 500_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sense_a,
  input  logic       sense_b,
  output logic [1:0] lamp_a,
  output logic [1:0] lamp_b
);

  localparam int CW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  localparam logic [1:0] GREEN  = 2'b00;
  localparam logic [1:0] YELLOW = 2'b01;
  localparam logic [1:0] RED    = 2'b10;

  typedef enum logic [1:0] {
    A_GO   = 2'b00,
    A_WARN = 2'b01,
    B_GO   = 2'b10,
    B_WARN = 2'b11
  } phase_t;

  phase_t        phase, phase_nx;
  logic [CW-1:0] cnt;
  logic          step;

  assign step = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      A_GO:   if (!sense_a) phase_nx = A_WARN;
      A_WARN: phase_nx = B_GO;
      B_GO:   if (!sense_b) phase_nx = B_WARN;
      B_WARN: phase_nx = A_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       phase <= A_GO;
    else if (step) phase <= phase_nx;
  end

  assign lamp_a = phase[1] ? RED : (phase[0] ? YELLOW : GREEN);
  assign lamp_b = !phase[1] ? RED : (phase[0] ? YELLOW : GREEN);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (phase == A_GO && cnt == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase));

  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

  p_a_stay_r3: assert property (@(posedge clk) disable iff (rst)
    (step && phase == A_GO && sense_a) |=> phase == A_GO);

  p_a_leave_r4: assert property (@(posedge clk) disable iff (rst)
    (step && phase == A_GO && !sense_a) |=> (lamp_a == YELLOW && lamp_b == RED));

  p_to_b_r5: assert property (@(posedge clk) disable iff (rst)
    (step && phase == A_WARN) |=> (lamp_a == RED && lamp_b == GREEN));

  p_b_stay_r6: assert property (@(posedge clk) disable iff (rst)
    (step && phase == B_GO && sense_b) |=> phase == B_GO);

  p_b_leave_r7: assert property (@(posedge clk) disable iff (rst)
    (step && phase == B_GO && !sense_b) |=> (lamp_a == RED && lamp_b == YELLOW));

  p_to_a_r8: assert property (@(posedge clk) disable iff (rst)
    (step && phase == B_WARN) |=> (lamp_a == GREEN && lamp_b == RED));

  p_one_red_r10: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == RED || lamp_b == RED));

endmodule

// File: tb/sim_traffic_phase_ctrl.sv
module sim_traffic_phase_ctrl;
  localparam int N = 4;
  localparam logic [3:0] S0 = 4'b00_10, S1 = 4'b01_10, S2 = 4'b10_00, S3 = 4'b10_01;

  logic clk = 1'b0, rst = 1'b1, sense_a = 1'b1, sense_b = 1'b0;
  logic [1:0] lamp_a, lamp_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  traffic_phase_ctrl #(.STEP_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if ({lamp_a, lamp_b} !== exp) begin
      fails++;
      $display("FAIL %s: lamps actual %b expected %b", tag, {lamp_a, lamp_b}, exp);
    end
    checks++;
    if (lamp_a != 2'b10 && lamp_b != 2'b10) begin
      fails++;
      $display("FAIL R10: no red, actual %b expected one road 10", {lamp_a, lamp_b});
    end
  endtask

  task automatic step_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step_wait(3);
    check("R1 reset", S0);
    rst = 1'b0;
  endtask

  task automatic t_hold_a;
    sense_a = 1'b1; sense_b = 1'b1;
    for (int i = 1; i < N; i++) begin
      step_wait(1);
      check("R2 before first step", S0);
    end
    step_wait(1);
    check("R3 A held, B ignored", S0);
  endtask

  task automatic t_glitch;
    sense_a = 1'b0;
    step_wait(2);
    sense_a = 1'b1;
    step_wait(N - 2);
    check("R9 glitch ignored", S0);
  endtask

  task automatic t_leave_a;
    sense_a = 1'b0;
    step_wait(N - 1);
    check("R2 no early move", S0);
    step_wait(1);
    check("R4 A to yellow", S1);
  endtask

  task automatic t_to_b;
    sense_a = 1'b1; sense_b = 1'b0;
    step_wait(N);
    check("R5 yellow to B green", S2);
  endtask

  task automatic t_hold_b;
    sense_a = 1'b1; sense_b = 1'b1;
    step_wait(N);
    check("R6 B held, A ignored", S2);
    sense_a = 1'b0;
    step_wait(N);
    check("R6 B held again", S2);
  endtask

  task automatic t_leave_b;
    sense_b = 1'b0;
    step_wait(N);
    check("R7 B to yellow", S3);
    sense_a = 1'b0; sense_b = 1'b1;
    step_wait(N);
    check("R8 back to A green", S0);
  endtask

  task automatic t_midreset;
    sense_a = 1'b0;
    step_wait(N);
    check("R4 again", S1);
    step_wait(2);
    rst = 1'b1;
    step_wait(1);
    check("R1 mid-run reset", S0);
    rst = 1'b0;
    step_wait(N - 1);
    check("R11 prescaler restarted", S0);
    step_wait(1);
    check("R11 first step after reset", S1);
  endtask

  initial begin
    t_reset();
    t_hold_a();
    t_glitch();
    t_leave_a();
    t_to_b();
    t_hold_b();
    t_leave_b();
    t_midreset();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule